// File: doc/BRIEF.md
# Emergency Output Shutdown Controller

This block sits between a six-channel multi-pulse waveform generator and its output pins. It watches an active-low external trip input. When the shutdown function is armed and the trip input is accepted as low, every enabled output stops following the generated waveform. Each one is held at a per-pin idle level that software has written to a port data register.

The override acts only on the pin path. The waveform generator, its timer, its position detection and its buffer-to-register transfers are outside this block and keep running. The outputs therefore resume the live waveform as soon as the trip is released.

The raw trip pin first passes through a two-stage synchronizer. It then goes through a hold-time noise filter, which can be bypassed with a select bit. A sticky flag records each trip, and that flag can raise an interrupt request.

Top module: `trip_shutdown_ctrl`

## Requirements
- R1: For each of the six outputs, `pin_oe_o[i]` equals `oe_i[i]`. While no trip is in force, `pin_o[i]` is `wave_i[i]` when `oe_i[i]`=1 and `idle_lvl_i[i]` when `oe_i[i]`=0.
- R2: With `arm_i`=0 the trip input has no effect: the outputs follow R1 and `flag_o` is not set.
- R3: With `arm_i`=1 and the accepted trip level low, every output with `oe_i[i]`=1 drives `idle_lvl_i[i]`.
- R4: The outputs return to `wave_i` in the same cycle that the accepted trip level returns high. The override is combinational from the accepted level.
- R5: With filtering selected (`filt_sel_i`=1), a new trip level is accepted only after the synchronized input has differed from the accepted level on N consecutive clock edges. From the raw pin, the accepted level changes on the (N+2)th rising edge after the change. A pulse lasting N-1 edges is ignored, and one lasting N edges is accepted.
- R6: N is selected by `filt_len_i`: 2'b00 gives 4, 2'b01 gives 8, 2'b10 gives 16 and 2'b11 gives 32.
- R7: With `filt_sel_i`=0, the accepted level is the synchronized pin, which changes on the 2nd rising edge after the raw pin changes.
- R8: `flag_o` sets on any edge where the block is armed and the accepted level is low. It stays set until a `flag_clr_i` pulse, and setting wins over a simultaneous clear.
- R9: `irq_o` is 1 exactly when `flag_o`=1 and `irq_en_i`=1.
- R10: After reset the accepted level is high (not tripped), `flag_o` is 0 and the outputs follow R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trip_n_i | input | 1 | Raw external trip pin, active low |
| arm_i | input | 1 | Arms the shutdown function |
| filt_sel_i | input | 1 | 1 selects the filtered trip level, 0 selects the synchronized level |
| filt_len_i | input | 2 | Filter hold-length select (4/8/16/32 clocks) |
| wave_i | input | 6 | Waveform bits from the pulse generator |
| oe_i | input | 6 | Per-pin waveform output enables |
| idle_lvl_i | input | 6 | Per-pin inactive levels from the port data register |
| irq_en_i | input | 1 | Interrupt enable |
| flag_clr_i | input | 1 | One-cycle pulse that clears the trip flag |
| pin_o | output | 6 | Pin values |
| pin_oe_o | output | 6 | Pin waveform-drive enables |
| flag_o | output | 1 | Sticky trip flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions check several rules on every cycle:
- a disarmed block passes the waveform or idle level straight through;
- an armed, tripped block forces the idle level on every enabled pin;
- the filter counter clears whenever the input agrees with the accepted level;
- the accepted level moves only when the counter has reached its limit;
- the flag sets on a trip and holds when left alone.

Only the bench scenarios can show the exact edge on which a trip is accepted for each hold length. They also show that a pulse one edge too short is ignored while one of exactly N edges is accepted, and that the waveform returns on the release edge. The remaining scenario covers a clear that arrives while the trip is still active.

// File: rtl/trip_pkg.sv
package trip_pkg;
  localparam int unsigned NUM_PINS = 6;
  localparam int unsigned LEN_W    = 2;
  localparam int unsigned BASE_LEN = 4;

  typedef enum logic [LEN_W-1:0] {
    FLT_4  = 2'b00,
    FLT_8  = 2'b01,
    FLT_16 = 2'b10,
    FLT_32 = 2'b11
  } filt_len_e;
endpackage

// File: rtl/trip_sync.sv
module trip_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= {STAGES{RST_VAL}};
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/trip_filter.sv
module trip_filter #(
  parameter int unsigned BASE_LEN = 4,
  parameter int unsigned LEN_W    = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sample_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             level_o
);
  localparam int unsigned MAX_LEN = BASE_LEN << ((1 << LEN_W) - 1);
  localparam int unsigned CNT_W   = $clog2(MAX_LEN);

  logic [CNT_W-1:0] cnt_q, lim;
  logic             level_q, differ, hit;

  always_comb begin
    lim    = CNT_W'((BASE_LEN << len_i) - 1);
    differ = sample_i != level_q;
    // >= keeps a shortened window safe if len_i changes mid-count
    hit    = differ && (cnt_q >= lim);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      level_q <= 1'b1;
    end else if (!differ) begin
      cnt_q   <= '0;
    end else if (hit) begin
      cnt_q   <= '0;
      level_q <= sample_i;
    end else begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  assign level_o = level_q;

  p_cnt_clear_r5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_i == level_o) |=> (cnt_q == '0));

  p_accept_at_limit_r5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_q != $past(level_q)) |-> ($past(cnt_q) >= $past(lim)));
endmodule

// File: rtl/trip_flag.sv
module trip_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic en_i,
  output logic flag_o,
  output logic irq_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & en_i;

  p_flag_set_r8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_o);

  p_flag_hold_r8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_i && !clr_i) |=> $stable(flag_o));
endmodule

// File: rtl/pin_gate.sv
module pin_gate #(
  parameter int unsigned W = 6
) (
  input  logic         force_i,
  input  logic [W-1:0] oe_i,
  input  logic [W-1:0] wave_i,
  input  logic [W-1:0] idle_i,
  output logic [W-1:0] pin_o,
  output logic [W-1:0] pin_oe_o
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    logic drive_wave;
    assign drive_wave  = oe_i[i] & ~force_i;
    assign pin_o[i]    = drive_wave ? wave_i[i] : idle_i[i];
    assign pin_oe_o[i] = oe_i[i];
  end
endmodule

// File: rtl/trip_shutdown_ctrl.sv
module trip_shutdown_ctrl
  import trip_pkg::*;
#(
  parameter int unsigned PINS        = NUM_PINS,
  parameter int unsigned FILT_BASE   = BASE_LEN,
  parameter int unsigned FILT_LEN_W  = LEN_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  trip_n_i,
  input  logic                  arm_i,
  input  logic                  filt_sel_i,
  input  logic [FILT_LEN_W-1:0] filt_len_i,
  input  logic [PINS-1:0]       wave_i,
  input  logic [PINS-1:0]       oe_i,
  input  logic [PINS-1:0]       idle_lvl_i,
  input  logic                  irq_en_i,
  input  logic                  flag_clr_i,
  output logic [PINS-1:0]       pin_o,
  output logic [PINS-1:0]       pin_oe_o,
  output logic                  flag_o,
  output logic                  irq_o
);
  logic sync_lvl, filt_lvl, trip_lvl, tripped;

  trip_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (trip_n_i),
    .q_o   (sync_lvl)
  );

  trip_filter #(.BASE_LEN(FILT_BASE), .LEN_W(FILT_LEN_W)) i_filter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sample_i(sync_lvl),
    .len_i   (filt_len_i),
    .level_o (filt_lvl)
  );

  assign trip_lvl = filt_sel_i ? filt_lvl : sync_lvl;
  assign tripped  = arm_i & ~trip_lvl;

  trip_flag i_flag (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (tripped),
    .clr_i (flag_clr_i),
    .en_i  (irq_en_i),
    .flag_o(flag_o),
    .irq_o (irq_o)
  );

  pin_gate #(.W(PINS)) i_gate (
    .force_i (tripped),
    .oe_i    (oe_i),
    .wave_i  (wave_i),
    .idle_i  (idle_lvl_i),
    .pin_o   (pin_o),
    .pin_oe_o(pin_oe_o)
  );

  p_disarmed_r2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !arm_i |-> (pin_o == ((oe_i & wave_i) | (~oe_i & idle_lvl_i))));

  p_forced_idle_r3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_i && !trip_lvl) |-> ((pin_o & oe_i) == (idle_lvl_i & oe_i)));

  p_irq_gated_r9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (flag_o && irq_en_i));
endmodule

// File: tb/test_trip_shutdown_ctrl.sv
module test_trip_shutdown_ctrl;
  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       trip_n_i = 1'b1, arm_i = 1'b0, filt_sel_i = 1'b0;
  logic [1:0] filt_len_i = 2'b00;
  logic [5:0] wave_i = '0, oe_i = '0, idle_lvl_i = '0;
  logic       irq_en_i = 1'b0, flag_clr_i = 1'b0;
  logic [5:0] pin_o, pin_oe_o;
  logic       flag_o, irq_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  trip_shutdown_ctrl i_trip_shutdown_ctrl (.*);

  // arm, trip_n, oe, idle, wave
  typedef struct packed {
    logic arm; logic trip_n; logic [5:0] oe; logic [5:0] idle; logic [5:0] wave;
  } vec_t;
  localparam vec_t VECS [8] = '{
    '{1'b0, 1'b1, 6'h3f, 6'h00, 6'h2a},
    '{1'b0, 1'b0, 6'h3f, 6'h15, 6'h2a},
    '{1'b1, 1'b1, 6'h0f, 6'h33, 6'h3c},
    '{1'b1, 1'b0, 6'h0f, 6'h33, 6'h3c},
    '{1'b1, 1'b0, 6'h3f, 6'h00, 6'h3f},
    '{1'b1, 1'b0, 6'h00, 6'h2d, 6'h12},
    '{1'b1, 1'b1, 6'h30, 6'h01, 6'h2e},
    '{1'b0, 1'b0, 6'h21, 6'h1e, 6'h33}
  };

  function automatic logic [5:0] model(logic arm, logic lvl, logic [5:0] oe,
                                       logic [5:0] idle, logic [5:0] wave);
    logic frc = arm & ~lvl;
    return (oe & ~{6{frc}} & wave) | ((~oe | {6{frc}}) & idle);
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic clear_flag();
    flag_clr_i = 1'b1; step(1); flag_clr_i = 1'b0;
  endtask

  // filtered trip, release and glitch for one hold length
  task automatic filt_run(logic [1:0] len);
    int n = 4 << len;
    filt_len_i = len; filt_sel_i = 1'b1; arm_i = 1'b1;
    oe_i = 6'h3f; wave_i = 6'h2a; idle_lvl_i = 6'h15;
    step(2); clear_flag(); step(1);
    trip_n_i = 1'b0;
    step(n + 1); check("R5/R6 before accept", {2'b0, pin_o}, 8'h2a);
    step(1);     check("R5/R6 R3 at accept", {2'b0, pin_o}, 8'h15);
    trip_n_i = 1'b1;
    step(n + 1); check("R4 held before release", {2'b0, pin_o}, 8'h15);
    step(1);     check("R4 wave on release", {2'b0, pin_o}, 8'h2a);
    clear_flag(); step(1);
    trip_n_i = 1'b0; step(n - 1); trip_n_i = 1'b1;
    step(n + 4);
    check("R5 short pulse pin", {2'b0, pin_o}, 8'h2a);
    check("R5 short pulse flag", {7'b0, flag_o}, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R10 reset state, armed with pin high
    arm_i = 1'b1; oe_i = 6'h3f; wave_i = 6'h2a; idle_lvl_i = 6'h15;
    step(2);
    check("R10 pin in reset", {2'b0, pin_o}, 8'h2a);
    check("R10 flag in reset", {6'b0, irq_o, flag_o}, 8'h00);
    rst_ni = 1'b1; step(3);
    check("R10 pin after reset", {2'b0, pin_o}, 8'h2a);

    // table walk, unfiltered path (R1 R2 R3)
    filt_sel_i = 1'b0;
    foreach (VECS[k]) begin
      arm_i = VECS[k].arm; trip_n_i = VECS[k].trip_n; oe_i = VECS[k].oe;
      idle_lvl_i = VECS[k].idle; wave_i = VECS[k].wave;
      step(3);
      check("R1/R2/R3 pin", {2'b0, pin_o},
            {2'b0, model(VECS[k].arm, VECS[k].trip_n, VECS[k].oe, VECS[k].idle, VECS[k].wave)});
      check("R1 pin_oe", {2'b0, pin_oe_o}, {2'b0, VECS[k].oe});
    end

    // R2 disarmed: trip low never sets flag
    trip_n_i = 1'b1; arm_i = 1'b0; step(3); clear_flag();
    trip_n_i = 1'b0; step(6);
    check("R2 flag stays clear", {7'b0, flag_o}, 8'h00);
    oe_i = 6'h3f; wave_i = 6'h0f; idle_lvl_i = 6'h30;
    arm_i = 1'b1; #1;
    check("R3 arm forces at once", {2'b0, pin_o}, 8'h30);

    // R7 unfiltered latency
    trip_n_i = 1'b1; step(3); clear_flag();
    trip_n_i = 1'b0; step(1);
    check("R7 edge 1 not yet", {2'b0, pin_o}, 8'h0f);
    step(1);
    check("R7 edge 2 forced", {2'b0, pin_o}, 8'h30);

    // R8/R9 flag, set wins over clear, irq gating
    step(1);
    check("R8 flag set", {7'b0, flag_o}, 8'h01);
    check("R9 irq masked", {7'b0, irq_o}, 8'h00);
    irq_en_i = 1'b1; #1;
    check("R9 irq enabled", {7'b0, irq_o}, 8'h01);
    clear_flag();
    check("R8 set wins over clear", {7'b0, flag_o}, 8'h01);
    trip_n_i = 1'b1; step(3);
    check("R8 sticky after release", {7'b0, flag_o}, 8'h01);
    clear_flag();
    check("R8 cleared", {7'b0, flag_o}, 8'h00);
    check("R9 irq drops", {7'b0, irq_o}, 8'h00);
    irq_en_i = 1'b0;

    // R5 R6 per hold length
    for (int l = 0; l < 4; l++) filt_run(2'(l));

    // R5 boundary: exactly N edges low is accepted (N=4)
    filt_len_i = 2'b00; step(2); clear_flag(); step(1);
    trip_n_i = 1'b0; step(4); trip_n_i = 1'b1;
    step(12);
    check("R5 N-edge pulse accepted", {7'b0, flag_o}, 8'h01);
    check("R5 released after pulse", {2'b0, pin_o}, 8'h2a);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule